// File: doc/BRIEF.md
# Bounded Upward Stack Pointer

This block holds the pointer of a word-aligned software stack that grows toward higher addresses, and it checks every stack access against an upper limit and a fixed lower floor. The caller issues single-word pushes, pops and direct pointer or limit writes. It can also issue a two-word return-address push, either for a plain subroutine call or for exception entry. For each access the block drives the memory address, the write data and a read or write strobe in the same cycle. The pointer register updates on the following clock edge.

An access that would go out of bounds is suppressed. The pointer keeps its value and a one-cycle trap pulse is reported together with the offending address. Reaching the limit exactly is allowed. Only the push after that is refused. The return-address push writes the low 16 bits of the program counter first. The second word carries the remaining counter bits in its low byte. Its upper byte is zero for a call and holds the caller's status byte for exception entry.

The control is a two-state machine. **ST_IDLE** accepts requests. **ST_PC_HI** writes the second word of a return-address push. The transitions are:
- **T_START**: ST_IDLE to ST_PC_HI, when a call or exception push writes its first word.
- **T_ABORT**: stay in ST_IDLE, when that first word traps.
- **T_FINISH**: ST_PC_HI to ST_IDLE, always after one cycle, whether or not the second word traps.
- **T_HOLD**: stay in ST_IDLE, for every other request.

Top module: `stkptr_guard`

## Requirements
- R1: After reset the pointer reads 0x0800, `busy` is low, no memory strobe is active and `trap_pulse` is low.
- R2: Writes to the pointer and to the limit clear bit 0 of the written value. A limit written as 0x1237 behaves as 0x1236.
- R3: A single push writes `push_data` at the current pointer address with `mem_we` high, and the pointer is 2 higher after the next clock edge.
- R4: A pop reads at the pointer minus 2 with `mem_re` high, and the pointer is 2 lower after the next clock edge.
- R5: A push whose address equals the limit proceeds without a trap. A push whose address is above the limit is suppressed: no `mem_we`, and the pointer is unchanged.
- R6: An access whose address would lie below the floor 0x0800 is suppressed and traps. This covers a pop at pointer 0x0800 (address 0x07FE) and a push after the pointer has been written below the floor.
- R7: A refused access raises `trap_pulse` for exactly one cycle, in the cycle after the request, with `trap_addr` holding the refused address.
- R8: A call push writes two words in consecutive cycles. The first is `pc_in[15:0]` at the pointer. The second, written while `busy` is high, is {8'h00, zero-extended `pc_in[22:16]`} at the pointer plus 2. The pointer ends 4 higher.
- R9: An exception push behaves like R8, except that the upper byte of the second word is `status_lo`.
- R10: Request priority in ST_IDLE is: pointer write, then exception, then call, then push, then pop. Requests presented while `busy` is high are ignored.
- R11: If the first word of a return-address push traps, no second word is written and `busy` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sp_wr | input | 1 | Direct pointer write |
| sp_wdata | input | 16 | Pointer write value |
| lim_wr | input | 1 | Limit register write |
| lim_wdata | input | 16 | Limit write value |
| push_req | input | 1 | Single-word push |
| push_data | input | 16 | Word to push |
| pop_req | input | 1 | Single-word pop |
| call_req | input | 1 | Return-address push for a call |
| exc_req | input | 1 | Return-address push for exception entry |
| pc_in | input | 23 | Program counter to push |
| status_lo | input | 8 | Status byte merged on exception entry |
| mem_addr | output | 16 | Stack access address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 16 | Write data |
| sp_out | output | 16 | Current pointer |
| busy | output | 1 | Second word of a return-address push in progress |
| trap_pulse | output | 1 | Stack error, one cycle |
| trap_addr | output | 16 | Address that was refused |

## Verification
The assertions check, on every cycle, the invariants that hold at the ports. These are: pointer alignment, address placement and pointer movement for every granted push and pop, no granted access below the floor, the pointer freezing on a trap, and `busy` lasting one cycle. The bench's scenarios are what demonstrate the rest. They show the exact limit boundary, where the push at the limit is accepted and the next one refused. They also show the content and order of the two return-address words, the status-byte merge, the abort of a sequence, the request priority, and the limit alignment, which only becomes visible through where a trap occurs.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_PC_HI = 1'b1
    } stk_state_e;
endpackage

// File: rtl/stk_bounds.sv
// Decides whether the next push or pop would leave the legal window.
module stk_bounds #(
    parameter int          AW    = 16,
    parameter logic [15:0] FLOOR = 16'h0800
) (
    input  logic [AW-1:0] sp,
    input  logic [AW-1:0] lim,
    output logic          push_bad,
    output logic          pop_bad
);
    localparam logic [AW-1:0] FLOOR_W   = AW'(FLOOR);
    localparam logic [AW-1:0] POP_FLOOR = AW'(FLOOR) + AW'(2);

    always_comb begin
        push_bad = (sp > lim) || (sp < FLOOR_W);
        pop_bad  = (sp < POP_FLOOR);
    end
endmodule

// File: rtl/stk_hiword.sv
// Forms the upper word of a pushed return address.
module stk_hiword #(
    parameter int PCW = 23
) (
    input  logic [PCW-17:0] pc_upper,
    input  logic [7:0]      status_lo,
    input  logic            from_exc,
    output logic [15:0]     word
);
    localparam int HB = PCW - 16;
    logic [7:0] low_byte;

    generate
        if (HB >= 8) begin : g_full
            assign low_byte = pc_upper[7:0];
        end else begin : g_pad
            assign low_byte = {{(8-HB){1'b0}}, pc_upper};
        end
    endgenerate

    assign word = {(from_exc ? status_lo : 8'h00), low_byte};
endmodule

// File: rtl/stkptr_guard.sv
module stkptr_guard #(
    parameter int          AW       = 16,
    parameter int          PCW      = 23,
    parameter logic [15:0] RESET_SP = 16'h0800,
    parameter logic [15:0] FLOOR    = 16'h0800
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sp_wr,
    input  logic [AW-1:0]  sp_wdata,
    input  logic           lim_wr,
    input  logic [AW-1:0]  lim_wdata,
    input  logic           push_req,
    input  logic [15:0]    push_data,
    input  logic           pop_req,
    input  logic           call_req,
    input  logic           exc_req,
    input  logic [PCW-1:0] pc_in,
    input  logic [7:0]     status_lo,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_we,
    output logic           mem_re,
    output logic [15:0]    mem_wdata,
    output logic [AW-1:0]  sp_out,
    output logic           busy,
    output logic           trap_pulse,
    output logic [AW-1:0]  trap_addr
);
    import stk_pkg::*;

    localparam int            HB   = PCW - 16;
    localparam logic [AW-1:0] STEP = AW'(2);

    stk_state_e      state, nxt;
    logic [AW-1:0]   sp_q, sp_d, lim_q;
    logic            seq_exc_q;
    logic [HB-1:0]   seq_pc_q;
    logic            trap_d;
    logic [AW-1:0]   taddr_d;
    logic            seq_start;
    logic            push_bad, pop_bad;
    logic [15:0]     hi_word;

    stk_bounds #(.AW(AW), .FLOOR(FLOOR)) u_bounds (
        .sp       (sp_q),
        .lim      (lim_q),
        .push_bad (push_bad),
        .pop_bad  (pop_bad)
    );

    stk_hiword #(.PCW(PCW)) u_hiword (
        .pc_upper  (seq_pc_q),
        .status_lo (status_lo_q),
        .from_exc  (seq_exc_q),
        .word      (hi_word)
    );

    logic [7:0] status_lo_q;

    // State and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            sp_q        <= AW'(RESET_SP);
            seq_exc_q   <= 1'b0;
            seq_pc_q    <= '0;
            status_lo_q <= 8'h00;
            trap_pulse  <= 1'b0;
            trap_addr   <= '0;
        end else begin
            state      <= nxt;
            sp_q       <= sp_d;
            trap_pulse <= trap_d;
            if (trap_d) begin
                trap_addr <= taddr_d;
            end
            if (seq_start) begin
                seq_exc_q   <= exc_req;
                seq_pc_q    <= pc_in[PCW-1:16];
                status_lo_q <= status_lo;
            end
        end
    end

    // Limit has no reset value; software must write it before use
    always_ff @(posedge clk) begin
        if (lim_wr) begin
            lim_q <= {lim_wdata[AW-1:1], 1'b0};
        end
    end

    // Next state and outputs
    always_comb begin
        nxt       = state;
        sp_d      = sp_q;
        mem_addr  = sp_q;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = push_data;
        trap_d    = 1'b0;
        taddr_d   = sp_q;
        seq_start = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (sp_wr) begin
                    sp_d = {sp_wdata[AW-1:1], 1'b0};
                end else if (exc_req || call_req) begin
                    mem_wdata = pc_in[15:0];
                    if (push_bad) begin
                        trap_d = 1'b1;              // T_ABORT
                    end else begin
                        mem_we    = 1'b1;
                        sp_d      = sp_q + STEP;
                        seq_start = 1'b1;
                        nxt       = ST_PC_HI;       // T_START
                    end
                end else if (push_req) begin
                    if (push_bad) begin
                        trap_d = 1'b1;
                    end else begin
                        mem_we = 1'b1;
                        sp_d   = sp_q + STEP;
                    end
                end else if (pop_req) begin
                    mem_addr = sp_q - STEP;
                    taddr_d  = sp_q - STEP;
                    if (pop_bad) begin
                        trap_d = 1'b1;
                    end else begin
                        mem_re = 1'b1;
                        sp_d   = sp_q - STEP;
                    end
                end
            end
            ST_PC_HI: begin
                mem_wdata = hi_word;
                nxt       = ST_IDLE;                // T_FINISH
                if (push_bad) begin
                    trap_d = 1'b1;
                end else begin
                    mem_we = 1'b1;
                    sp_d   = sp_q + STEP;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign sp_out = sp_q;
    assign busy   = (state == ST_PC_HI);
endmodule

// File: rtl/stk_guard_chk.sv
module stk_guard_chk #(
    parameter int          AW    = 16,
    parameter logic [15:0] FLOOR = 16'h0800
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] sp_out,
    input logic          busy,
    input logic          trap_pulse
);
    AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        sp_out[0] == 1'b0); // R2
    AST_PUSH_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == sp_out); // R3
    AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_out == $past(sp_out) + AW'(2)); // R3
    AST_POP_BELOW_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> mem_addr == sp_out - AW'(2)); // R4
    AST_POP_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp_out == $past(sp_out) - AW'(2)); // R4
    AST_NO_ACCESS_BELOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> mem_addr >= AW'(FLOOR)); // R6
    AST_TRAP_FREEZES_SP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> sp_out == $past(sp_out)); // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R10
    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R8
endmodule

bind stkptr_guard stk_guard_chk #(.AW(AW), .FLOOR(FLOOR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .sp_out     (sp_out),
    .busy       (busy),
    .trap_pulse (trap_pulse)
);

// File: tb/stkptr_guard_tb.sv
`timescale 1ns/1ps
module stkptr_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sp_wr = 0, lim_wr = 0, push_req = 0, pop_req = 0, call_req = 0, exc_req = 0;
    logic [15:0] sp_wdata = 0, lim_wdata = 0, push_data = 0;
    logic [22:0] pc_in = 0;
    logic [7:0]  status_lo = 0;
    logic [15:0] mem_addr, mem_wdata, sp_out, trap_addr;
    logic        mem_we, mem_re, busy, trap_pulse;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stkptr_guard u_dut (
        .clk(clk), .rst_n(rst_n), .sp_wr(sp_wr), .sp_wdata(sp_wdata),
        .lim_wr(lim_wr), .lim_wdata(lim_wdata), .push_req(push_req),
        .push_data(push_data), .pop_req(pop_req), .call_req(call_req),
        .exc_req(exc_req), .pc_in(pc_in), .status_lo(status_lo),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .sp_out(sp_out), .busy(busy),
        .trap_pulse(trap_pulse), .trap_addr(trap_addr)
    );

    // {op[35:34] 1=push 2=pop, addr[33:18], granted[17], sp_after[16:1], trap[0]}
    localparam logic [35:0] VEC [0:10] = '{
        {2'd1, 16'h0800, 1'b1, 16'h0802, 1'b0},
        {2'd1, 16'h0802, 1'b1, 16'h0804, 1'b0},
        {2'd1, 16'h0804, 1'b1, 16'h0806, 1'b0},
        {2'd1, 16'h0806, 1'b1, 16'h0808, 1'b0},
        {2'd1, 16'h0808, 1'b0, 16'h0808, 1'b1},
        {2'd2, 16'h0806, 1'b1, 16'h0806, 1'b0},
        {2'd2, 16'h0804, 1'b1, 16'h0804, 1'b0},
        {2'd2, 16'h0802, 1'b1, 16'h0802, 1'b0},
        {2'd2, 16'h0800, 1'b1, 16'h0800, 1'b0},
        {2'd2, 16'h07FE, 1'b0, 16'h0800, 1'b1},
        {2'd1, 16'h0800, 1'b1, 16'h0802, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        sp_wr = 0; lim_wr = 0; push_req = 0; pop_req = 0; call_req = 0; exc_req = 0;
    endtask

    task automatic set_sp(input logic [15:0] v);
        @(negedge clk); sp_wr = 1; sp_wdata = v;
        @(negedge clk); idle_in();
    endtask

    task automatic set_lim(input logic [15:0] v);
        @(negedge clk); lim_wr = 1; lim_wdata = v;
        @(negedge clk); idle_in();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(sp_out == 16'h0800, "R1 sp", sp_out, 16'h0800);
        chk(!busy && !mem_we && !mem_re && !trap_pulse, "R1 idle", {busy, mem_we, mem_re, trap_pulse}, 0);

        set_lim(16'h0806);
        // Vector walk: R3 R4 R5 R6 R7
        for (int i = 0; i < 11; i++) begin
            logic [35:0] v;
            v = VEC[i];
            @(negedge clk);
            push_data = 16'hA000 + 16'(i);
            push_req = (v[35:34] == 2'd1);
            pop_req  = (v[35:34] == 2'd2);
            #1;
            if (v[35:34] == 2'd1) begin
                chk(mem_we == v[17], "R3/R5 we", mem_we, v[17]);
                if (v[17]) chk(mem_addr == v[33:18] && mem_wdata == push_data, "R3 addr/data", {mem_addr, mem_wdata}, {v[33:18], push_data});
            end else begin
                chk(mem_re == v[17], "R4/R6 re", mem_re, v[17]);
                if (v[17]) chk(mem_addr == v[33:18], "R4 addr", mem_addr, v[33:18]);
            end
            @(negedge clk); idle_in(); #1;
            chk(sp_out == v[16:1], "R3/R4/R5 sp", sp_out, v[16:1]);
            chk(trap_pulse == v[0], "R7 trap", trap_pulse, v[0]);
            if (v[0]) chk(trap_addr == v[33:18], "R7 trap_addr", trap_addr, v[33:18]);
        end
        @(negedge clk); #1;
        chk(!trap_pulse, "R7 pulse one cycle", trap_pulse, 0);

        // R2 alignment of pointer and limit
        set_sp(16'h1235); #1;
        chk(sp_out == 16'h1234, "R2 sp align", sp_out, 16'h1234);
        set_lim(16'h1237);
        set_sp(16'h1236);
        @(negedge clk); push_req = 1; #1;
        chk(mem_we, "R2 push at aligned limit", mem_we, 1);
        @(negedge clk); push_req = 1; #1;
        chk(!mem_we, "R2 push above aligned limit", mem_we, 0);
        @(negedge clk); idle_in(); #1;
        chk(trap_pulse && trap_addr == 16'h1238, "R2 trap addr", trap_addr, 16'h1238);

        // R8 call push, with a push during busy (R10)
        set_sp(16'h0900);
        @(negedge clk); call_req = 1; pc_in = 23'h5ABCDE; status_lo = 8'hC3; #1;
        chk(mem_we && mem_addr == 16'h0900 && mem_wdata == 16'hBCDE && !busy, "R8 first word", {mem_addr, mem_wdata}, {16'h0900, 16'hBCDE});
        @(negedge clk); idle_in(); push_req = 1; push_data = 16'h7777; #1;
        chk(busy && mem_we && mem_addr == 16'h0902 && mem_wdata == 16'h005A, "R8 second word", {mem_addr, mem_wdata}, {16'h0902, 16'h005A});
        @(negedge clk); idle_in(); #1;
        chk(sp_out == 16'h0904 && !busy, "R10 push ignored while busy", sp_out, 16'h0904);

        // R9 exception push
        @(negedge clk); exc_req = 1; status_lo = 8'hC3; #1;
        chk(mem_we && mem_addr == 16'h0904 && mem_wdata == 16'hBCDE, "R9 first word", mem_wdata, 16'hBCDE);
        @(negedge clk); idle_in(); status_lo = 8'h00; #1;
        chk(mem_we && mem_addr == 16'h0906 && mem_wdata == 16'hC35A, "R9 second word", mem_wdata, 16'hC35A);
        @(negedge clk); #1;
        chk(sp_out == 16'h0908, "R9 sp", sp_out, 16'h0908);

        // R10 priority
        @(negedge clk); sp_wr = 1; sp_wdata = 16'h0A00; push_req = 1; #1;
        chk(!mem_we, "R10 sp write beats push", mem_we, 0);
        @(negedge clk); idle_in(); #1;
        chk(sp_out == 16'h0A00, "R10 sp written", sp_out, 16'h0A00);
        @(negedge clk); push_req = 1; pop_req = 1; #1;
        chk(mem_we && !mem_re, "R10 push beats pop", {mem_we, mem_re}, 2'b10);
        @(negedge clk); idle_in(); #1;
        chk(sp_out == 16'h0A02, "R10 sp after push", sp_out, 16'h0A02);

        // R11 abort when first word traps
        set_sp(16'h1238);
        @(negedge clk); call_req = 1; #1;
        chk(!mem_we, "R11 first word refused", mem_we, 0);
        @(negedge clk); idle_in(); #1;
        chk(!busy && !mem_we && trap_pulse && sp_out == 16'h1238, "R11 no second word", {busy, mem_we, sp_out}, {2'b00, 16'h1238});

        // R5/R7 second word traps at limit
        set_sp(16'h1236);
        @(negedge clk); call_req = 1; #1;
        chk(mem_we, "R5 first word at limit", mem_we, 1);
        @(negedge clk); idle_in(); #1;
        chk(busy && !mem_we, "R5 second word refused", mem_we, 0);
        @(negedge clk); #1;
        chk(trap_pulse && trap_addr == 16'h1238 && sp_out == 16'h1238, "R7 second word trap", trap_addr, 16'h1238);

        // R6 push below floor
        set_sp(16'h0400);
        @(negedge clk); push_req = 1; #1;
        chk(!mem_we, "R6 push below floor", mem_we, 0);
        @(negedge clk); idle_in(); #1;
        chk(trap_pulse && trap_addr == 16'h0400 && sp_out == 16'h0400, "R6 trap below floor", trap_addr, 16'h0400);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule